// File: doc/BRIEF.md
# Digitizer Front-End Bring-Up Sequencer

This block controls the bring-up of a receive path fed by two data converters. A bring-up run is a fixed chain of five steps, always taken in the same order. Each step is handed to an outside agent through a one-hot request line and is finished when that agent raises the matching done line. The steps are:

- restart the receive clock synthesizer;
- restart the serial-to-parallel unpacking logic;
- retune the capture delays by phase alignment;
- line the two converters up against each other;
- wipe the fault flags.

A run can be started in three ways: by an explicit restart pulse, by the IO enable input rising, or by any change of the sample-clock selection. A new start request always aborts a run in progress and begins again at the first step. If a step does not finish within a bounded number of cycles, the run stops and a failure flag is raised.

The block also keeps three sticky fault flags. One flag per converter records that its capture window has become too narrow. A third flag records that the clock synthesizer lost lock after bring-up had finished. The user clock enable is gated off whenever the synthesizer is unlocked, and it stays off once the loss-of-lock flag is set.

Top module: `fe_init_seq`

## Requirements
- R1: `step_req` is one-hot or zero. A run raises bit 0 first. It moves from bit k to bit k+1 only in the cycle after `step_done[k]` is sampled high while bit k is raised. Step k is bit k: 0 synthesizer restart, 1 unpacker restart, 2 delay retune, 3 converter alignment, 4 flag wipe.
- R2: A start is taken on any of three conditions, each sampled at a clock edge:
  - `force_init` is high;
  - `io_enable` is high while it was low at the previous edge;
  - `clk_sel` differs from its value at the previous edge.

  After a start, `step_req` equals 5'b00001 in the following cycle.
- R3: `init_done` is low in the cycle after any start. It rises only in the cycle after step 4 completes, and `step_req` is zero while it is high.
- R4: A start taken while a run is active aborts that run and restarts at step 0, even if a done is present in the same cycle.
- R5: If the active step's done has not arrived after STEP_TIMEOUT cycles of request (16 by default), `init_fail` rises. `step_req` then goes to zero and `init_done` stays low until the next start. A start clears `init_fail`.
- R6: `adc_err[i]` becomes 1 in the cycle after `win_narrow[i]` is sampled high. It then holds, and is cleared only in the cycle after step 4 completes.
- R7: `pll_unlock` becomes 1 in the cycle after `pll_locked` is sampled low while `init_done` is high. It then holds until step 4 of a later run completes.
- R8: `user_clk_en` is high exactly when `init_done` is high, `pll_locked` is high and `pll_unlock` is low.
- R9: `cfg_reset_req` is a one-cycle pulse in the cycle after an `io_enable` rise is sampled. It is not raised by the other two start sources.
- R10: While reset is held, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_init | input | 1 | Explicit restart request |
| io_enable | input | 1 | IO enable level; a rising edge starts a run |
| clk_sel | input | SEL_W | Sample-clock selection; any change starts a run |
| pll_locked | input | 1 | Clock synthesizer lock indicator |
| win_narrow | input | NCONV | Per-converter capture-window-too-narrow indication |
| step_done | input | 5 | Per-step completion from the step agents |
| step_req | output | 5 | One-hot request for the active step |
| cfg_reset_req | output | 1 | Pulse asking for a converter register reset |
| init_done | output | 1 | Bring-up finished |
| init_fail | output | 1 | A step timed out |
| adc_err | output | NCONV | Sticky per-converter window fault |
| pll_unlock | output | 1 | Sticky loss-of-lock since bring-up |
| user_clk_en | output | 1 | Gated user clock enable |

## Verification
The hardest situation to reach is a start that lands in the same cycle as the done of the active step. The clock selection is changed exactly when a step agent answers, and the bench checks that the abort wins over the advance. A per-step latency table in the bench's handshake responders sets when each done arrives. One entry is set past the timeout limit to drive the failure path, and a forced restart then leads back to a clean run. A reference model updated every cycle checks every output, so the sticky flags are compared across the flag-wipe boundary, including fault pulses that arrive just before and just after it.

// File: rtl/fe_init_pkg.sv
package fe_init_pkg;
  localparam int NSTEP  = 5;
  localparam int STEP_W = $clog2(NSTEP);

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_DONE, SQ_FAIL} seq_state_e;
  typedef logic [STEP_W-1:0] step_idx_t;

  // One-hot request vector for a step index.
  function automatic logic [NSTEP-1:0] step_onehot(step_idx_t idx);
    logic [NSTEP-1:0] v;
    for (int k = 0; k < NSTEP; k++) v[k] = (idx == step_idx_t'(k));
    return v;
  endfunction

  function automatic logic is_last_step(step_idx_t idx);
    return idx == step_idx_t'(NSTEP - 1);
  endfunction

  // True when a step has waited its whole budget.
  function automatic logic budget_spent(int unsigned waited, int unsigned limit);
    return waited + 1 >= limit;
  endfunction
endpackage

// File: rtl/fe_init_trig.sv
module fe_init_trig #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_init,
  input  logic             io_enable,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             start_evt,
  output logic             io_rise
);
  logic             io_q;
  logic [SEL_W-1:0] sel_q;
  logic             sel_change;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q  <= 1'b0;
      sel_q <= '0;
    end else begin
      io_q  <= io_enable;
      sel_q <= clk_sel;
    end
  end

  assign io_rise    = io_enable & ~io_q;
  assign sel_change = (clk_sel != sel_q);
  assign start_evt  = force_init | io_rise | sel_change;
endmodule

// File: rtl/fe_init_fsm.sv
module fe_init_fsm
  import fe_init_pkg::*;
#(
  parameter int STEP_TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic [NSTEP-1:0] step_done,
  output logic [NSTEP-1:0] step_req,
  output logic             init_done,
  output logic             init_fail,
  output logic             clr_evt
);
  localparam int TMR_W = $clog2(STEP_TIMEOUT + 1);

  seq_state_e       state;
  step_idx_t        step;
  logic [TMR_W-1:0] tmr;
  logic             cur_done;
  logic             expired;

  assign step_req  = (state == SQ_RUN) ? step_onehot(step) : '0;
  assign cur_done  = |(step_req & step_done);
  assign expired   = budget_spent(int'(tmr), STEP_TIMEOUT);
  assign clr_evt   = (state == SQ_RUN) && is_last_step(step) && cur_done && !start_evt;
  assign init_done = (state == SQ_DONE);
  assign init_fail = (state == SQ_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      step  <= '0;
      tmr   <= '0;
    end else if (start_evt) begin
      state <= SQ_RUN;
      step  <= '0;
      tmr   <= '0;
    end else if (state == SQ_RUN) begin
      if (cur_done) begin
        tmr <= '0;
        if (is_last_step(step)) state <= SQ_DONE;
        else                    step  <= step + 1'b1;
      end else if (expired) begin
        state <= SQ_FAIL;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fe_init_sticky.sv
module fe_init_sticky #(
  parameter int NCONV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_evt,
  input  logic             init_done,
  input  logic             pll_locked,
  input  logic [NCONV-1:0] win_narrow,
  output logic [NCONV-1:0] adc_err,
  output logic             pll_unlock
);
  for (genvar i = 0; i < NCONV; i++) begin : g_conv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             adc_err[i] <= 1'b0;
      else if (clr_evt)       adc_err[i] <= 1'b0;
      else if (win_narrow[i]) adc_err[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pll_unlock <= 1'b0;
    else if (clr_evt)                  pll_unlock <= 1'b0;
    else if (init_done && !pll_locked) pll_unlock <= 1'b1;
  end
endmodule

// File: rtl/fe_init_seq.sv
module fe_init_seq
  import fe_init_pkg::*;
#(
  parameter int SEL_W        = 2,
  parameter int NCONV        = 2,
  parameter int STEP_TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_init,
  input  logic             io_enable,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             pll_locked,
  input  logic [NCONV-1:0] win_narrow,
  input  logic [NSTEP-1:0] step_done,
  output logic [NSTEP-1:0] step_req,
  output logic             cfg_reset_req,
  output logic             init_done,
  output logic             init_fail,
  output logic [NCONV-1:0] adc_err,
  output logic             pll_unlock,
  output logic             user_clk_en
);
  logic start_evt;
  logic io_rise;
  logic clr_evt;

  fe_init_trig #(.SEL_W(SEL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .force_init(force_init), .io_enable(io_enable),
    .clk_sel(clk_sel), .start_evt(start_evt), .io_rise(io_rise)
  );

  fe_init_fsm #(.STEP_TIMEOUT(STEP_TIMEOUT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .step_done(step_done),
    .step_req(step_req), .init_done(init_done), .init_fail(init_fail), .clr_evt(clr_evt)
  );

  fe_init_sticky #(.NCONV(NCONV)) u_sticky (
    .clk(clk), .rst_n(rst_n), .clr_evt(clr_evt), .init_done(init_done),
    .pll_locked(pll_locked), .win_narrow(win_narrow), .adc_err(adc_err),
    .pll_unlock(pll_unlock)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_reset_req <= 1'b0;
    else        cfg_reset_req <= io_rise;
  end

  assign user_clk_en = init_done & pll_locked & ~pll_unlock;
endmodule

// File: rtl/fe_init_seq_chk.sv
module fe_init_seq_chk #(
  parameter int NCONV = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_evt,
  input logic             clr_evt,
  input logic             pll_locked,
  input logic [4:0]       step_req,
  input logic [4:0]       step_done,
  input logic             cfg_reset_req,
  input logic             init_done,
  input logic             init_fail,
  input logic [NCONV-1:0] adc_err,
  input logic             pll_unlock,
  input logic             user_clk_en
);
  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(step_req)); // R1
  AST_ADVANCE_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req != 5'b0 && (step_req & step_done) == 5'b0 && !start_evt && !init_fail) |=> (step_req == $past(step_req) || init_fail)); // R1
  AST_START_TO_STEP0: assert property (@(posedge clk) disable iff (!rst_n) start_evt |=> step_req == 5'b00001); // R2
  AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n) start_evt |=> !init_done); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) init_done |-> step_req == 5'b0); // R3
  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n) (start_evt && step_req[4] && step_done[4]) |=> !init_done); // R4
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) init_fail |-> (!init_done && step_req == 5'b0)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (|adc_err && !clr_evt) |=> ((adc_err & $past(adc_err)) == $past(adc_err))); // R6
  AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (pll_unlock && !clr_evt) |=> pll_unlock); // R7
  AST_CLK_GATE: assert property (@(posedge clk) disable iff (!rst_n) (!pll_locked || pll_unlock) |-> !user_clk_en); // R8
  AST_CFG_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cfg_reset_req |=> !cfg_reset_req); // R9
endmodule

bind fe_init_seq fe_init_seq_chk #(.NCONV(NCONV)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .clr_evt(clr_evt),
  .pll_locked(pll_locked), .step_req(step_req), .step_done(step_done),
  .cfg_reset_req(cfg_reset_req), .init_done(init_done), .init_fail(init_fail),
  .adc_err(adc_err), .pll_unlock(pll_unlock), .user_clk_en(user_clk_en)
);

// File: tb/fe_init_seq_test.sv
`timescale 1ns/1ps
module fe_init_seq_test;
  localparam int TO = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       force_init = 1'b0, io_enable = 1'b0, pll_locked = 1'b1;
  logic [1:0] clk_sel = 2'd0, win_narrow = 2'd0;
  logic [4:0] step_done = 5'd0;
  logic [4:0] step_req;
  logic       cfg_reset_req, init_done, init_fail, pll_unlock, user_clk_en;
  logic [1:0] adc_err;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int lat[5] = '{2, 3, 1, 4, 2};
  int cnt[5] = '{0, 0, 0, 0, 0};

  // reference model state
  int m_state = 0, m_step = 0, m_tmr = 0;   // 0 idle, 1 run, 2 done, 3 fail
  bit m_io_q = 0, m_unl = 0, m_cfg = 0;
  bit [1:0] m_sel_q = 0, m_err = 0;

  always #10 clk = ~clk;

  fe_init_seq uut (
    .clk(clk), .rst_n(rst_n), .force_init(force_init), .io_enable(io_enable),
    .clk_sel(clk_sel), .pll_locked(pll_locked), .win_narrow(win_narrow),
    .step_done(step_done), .step_req(step_req), .cfg_reset_req(cfg_reset_req),
    .init_done(init_done), .init_fail(init_fail), .adc_err(adc_err),
    .pll_unlock(pll_unlock), .user_clk_en(user_clk_en)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model, one update per rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_step = 0; m_tmr = 0;
      m_io_q = 0; m_sel_q = 0; m_err = 0; m_unl = 0; m_cfg = 0;
    end else begin
      bit s, cd, clr, was_done;
      s = force_init || (io_enable && !m_io_q) || (clk_sel != m_sel_q);
      cd = (m_state == 1) && step_done[m_step];
      clr = (m_state == 1) && (m_step == 4) && cd && !s;
      was_done = (m_state == 2);
      for (int i = 0; i < 2; i++)
        if (clr) m_err[i] = 0; else if (win_narrow[i]) m_err[i] = 1;
      if (clr) m_unl = 0; else if (was_done && !pll_locked) m_unl = 1;
      m_cfg = io_enable && !m_io_q;
      if (s) begin
        m_state = 1; m_step = 0; m_tmr = 0;
      end else if (m_state == 1) begin
        if (cd) begin
          m_tmr = 0;
          if (m_step == 4) m_state = 2; else m_step = m_step + 1;
        end else if (m_tmr == TO - 1) m_state = 3;
        else m_tmr = m_tmr + 1;
      end
      m_io_q = io_enable;
      m_sel_q = clk_sel;
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_req;
      exp_req = (m_state == 1) ? (1 << m_step) : 0;
      chk(step_req == 5'(exp_req), "R1 step_req", step_req, exp_req);
      chk(init_done == (m_state == 2), "R3 init_done", init_done, m_state == 2);
      chk(init_fail == (m_state == 3), "R5 init_fail", init_fail, m_state == 3);
      chk(adc_err == m_err, "R6 adc_err", adc_err, m_err);
      chk(pll_unlock == m_unl, "R7 pll_unlock", pll_unlock, m_unl);
      chk(user_clk_en == ((m_state == 2) && pll_locked && !m_unl), "R8 user_clk_en",
          user_clk_en, (m_state == 2) && pll_locked && !m_unl);
      chk(cfg_reset_req == m_cfg, "R9 cfg_reset_req", cfg_reset_req, m_cfg);
    end
  end

  // Step agents: done rises once the request has been held lat[k] cycles.
  always @(negedge clk) begin
    #2;
    for (int k = 0; k < 5; k++) begin
      if (step_req[k]) begin
        cnt[k]++;
        step_done[k] = (cnt[k] >= lat[k]);
      end else begin
        cnt[k] = 0;
        step_done[k] = 1'b0;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  task automatic pulse_force();
    force_init = 1'b1;
    tick(1);
    force_init = 1'b0;
  endtask

  task automatic wait_end(int max);
    for (int i = 0; i < max && !init_done && !init_fail; i++) tick(1);
  endtask

  initial begin
    tick(3);
    chk(step_req == 0 && !init_done && !init_fail && adc_err == 0 && !pll_unlock
        && !user_clk_en && !cfg_reset_req, "R10 reset state", step_req, 0);
    rst_n = 1'b1;
    tick(2);
    // IO enable rise starts a run and asks for a register reset
    io_enable = 1'b1;
    @(negedge clk);
    chk(cfg_reset_req == 1, "R9 pulse after io rise", cfg_reset_req, 1);
    chk(step_req == 5'b00001, "R2 io rise starts step 0", step_req, 1);
    #3;
    wait_end(200);
    chk(init_done == 1, "R3 done after full run", init_done, 1);
    // window faults are sticky
    win_narrow = 2'b01; tick(1); win_narrow = 2'b00; tick(3);
    chk(adc_err == 2'b01, "R6 converter 0 flag held", adc_err, 1);
    win_narrow = 2'b10; tick(1); win_narrow = 2'b00; tick(2);
    // loss of lock after bring-up
    pll_locked = 1'b0; tick(1);
    chk(user_clk_en == 0, "R8 gated while unlocked", user_clk_en, 0);
    pll_locked = 1'b1; tick(2);
    chk(pll_unlock == 1 && user_clk_en == 0, "R7 unlock flag sticky", pll_unlock, 1);
    // forced restart clears flags at the wipe step
    pulse_force();
    chk(init_done == 0, "R3 done low after start", init_done, 0);
    chk(cfg_reset_req == 0, "R9 no pulse on force", cfg_reset_req, 0);
    win_narrow = 2'b10; tick(1); win_narrow = 2'b00;
    wait_end(200);
    chk(adc_err == 2'b00 && pll_unlock == 0, "R6 R7 cleared by rerun", adc_err, 0);
    chk(user_clk_en == 1, "R8 enabled after clean run", user_clk_en, 1);
    // selection change mid-run aborts and restarts
    lat = '{3, 3, 3, 3, 3};
    pulse_force(); tick(4);
    clk_sel = 2'd2;
    @(negedge clk);
    chk(step_req == 5'b00001, "R4 abort restarts at step 0", step_req, 1);
    #3;
    wait_end(200);
    chk(init_done == 1, "R4 restarted run completes", init_done, 1);
    // selection change exactly when the last step answers
    pulse_force();
    while (!step_req[4]) tick(1);
    while (!step_done[4]) tick(1);
    clk_sel = 2'd1;
    @(negedge clk);
    chk(init_done == 0 && step_req == 5'b00001, "R4 start beats last done", step_req, 1);
    #3;
    wait_end(200);
    // timeout on the retune step
    lat[2] = 100;
    pulse_force();
    wait_end(200);
    chk(init_fail == 1 && init_done == 0, "R5 timeout raises fail", init_fail, 1);
    tick(5);
    chk(step_req == 0, "R5 no request after fail", step_req, 0);
    lat[2] = 1;
    pulse_force();
    chk(init_fail == 0, "R5 start clears fail", init_fail, 0);
    wait_end(200);
    chk(init_done == 1, "R1 full order after recovery", init_done, 1);
    // re-enable IO
    io_enable = 1'b0; tick(2); io_enable = 1'b1; tick(1);
    wait_end(200);
    tick(2);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule